// File: doc/BRIEF.md
# Register Rename Table with Completion-Tag Wakeup

This block keeps one mapping entry for every architectural register of an out-of-order core. An entry holds a pending/ready flag and a result tag, which is the index of the result-buffer slot where the register's newest value lives or will be written. The tag is kept whether or not the value has been produced, so a consumer always learns where to look.

When a micro-operation issues, the table returns the flag and tag of each of its source registers at once. On the following clock edge it then remaps the destination register to the tag given to the new operation and marks that register pending. Execution units broadcast the tags of the results they finish. Each entry compares its own tag with every broadcast and becomes ready when one matches. The table never holds issue back for a register hazard: renaming removes write-after-read and write-after-write conflicts, and read-after-write conflicts are handed on as tags.

The bench and the checker rely on three same-cycle orderings. A source whose current tag is being broadcast in the same cycle is reported ready. A rename beats a wakeup aimed at the same entry in the same cycle. A source that names the operation's own destination sees the mapping from before the rename.

Top module: `rename_alias_table`

## Requirements
- R1: After reset every entry is ready, and the entry for register i holds tag i.
- R2: The source lookup outputs are combinational. For each source slot k, `src_ready[k]` and tag slice k of `src_tag` (bits k*TAG_W upward) give the entry selected by slice k of `iss_src_reg` (bits k*REG_W upward), whether or not `iss_valid` is high.
- R3: When `iss_valid` and `iss_dst_valid` are both high at a clock edge, the entry named by `iss_dst_reg` is not ready after that edge and holds `iss_new_tag`.
- R4: When port p has `cmp_valid[p]` high at an edge, every entry whose tag equals slice p of `cmp_tag` becomes ready after that edge and keeps its tag. An entry whose tag differs from every valid broadcast keeps its state.
- R5: A source whose selected entry's tag equals a valid broadcast tag in the same cycle is reported ready in that cycle.
- R6: If a rename and a matching broadcast reach the same entry at one edge, the rename wins. The entry is left not ready and holds the new tag.
- R7: A source slot that names the same register as the destination returns the mapping from before the rename.
- R8: A rename with `iss_valid` low or `iss_dst_valid` low changes no entry. A broadcast with its valid bit low wakes no entry.
- R9: Every broadcast port wakes entries on its own, and two ports may wake two different entries at the same edge.
- R10: Two source slots that name the same register return identical ready flags and tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all entries update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A micro-operation issues this cycle |
| iss_src_reg | input | NUM_SRC*REG_W | Source register numbers, slot k in bits k*REG_W upward |
| iss_dst_valid | input | 1 | The issuing operation writes a destination register |
| iss_dst_reg | input | REG_W | Destination register number |
| iss_new_tag | input | TAG_W | Result tag given to the issuing operation |
| src_ready | output | NUM_SRC | Ready flag per source slot, with same-cycle bypass |
| src_tag | output | NUM_SRC*TAG_W | Tag per source slot, slot k in bits k*TAG_W upward |
| cmp_valid | input | NUM_PORTS | Completion broadcast valid per port |
| cmp_tag | input | NUM_PORTS*TAG_W | Completion tag per port, port p in bits p*TAG_W upward |

## Verification
The checker watches four things on every cycle. It checks that a qualified rename leaves the named entry pending under the new tag, even when a wakeup for that entry comes in the same cycle. It checks that a matching valid broadcast wakes every entry not being renamed, that a cycle with no rename and no valid broadcast leaves the whole table unchanged, and that the source outputs carry the selected tag together with the bypassed ready flag. Only the bench scenarios can show the reset mapping, a source that reads its own destination before the update, a stale broadcast failing to wake a register renamed twice, and two ports waking different registers at one edge. Each of these needs an expected history of tags that the bench builds from the requirements.

// File: rtl/rat_pkg.sv
package rat_pkg;
    localparam int RAT_NUM_REGS  = 16;
    localparam int RAT_TAG_W     = 7;
    localparam int RAT_NUM_SRC   = 2;
    localparam int RAT_NUM_PORTS = 2;
endpackage

// File: rtl/rat_entry.sv
module rat_entry #(
    parameter int TAG_W     = 7,
    parameter int RESET_TAG = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rename_en,
    input  logic [TAG_W-1:0] rename_tag,
    input  logic             wake_hit,
    output logic             ready,
    output logic [TAG_W-1:0] tag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b1;
            tag   <= TAG_W'(RESET_TAG);
        end else if (rename_en) begin
            ready <= 1'b0;
            tag   <= rename_tag;
        end else if (wake_hit) begin
            ready <= 1'b1;
        end
    end
endmodule

// File: rtl/rat_wakeup.sv
module rat_wakeup #(
    parameter int TAG_W     = 7,
    parameter int NUM_PORTS = 2
) (
    input  logic [TAG_W-1:0]           entry_tag,
    input  logic [NUM_PORTS-1:0]       cmp_valid,
    input  logic [NUM_PORTS*TAG_W-1:0] cmp_tag,
    output logic                       hit
);
    always_comb begin
        hit = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cmp_valid[p] && (cmp_tag[p*TAG_W +: TAG_W] == entry_tag)) begin
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rat_src_read.sv
module rat_src_read #(
    parameter int NUM_REGS  = 16,
    parameter int TAG_W     = 7,
    parameter int NUM_PORTS = 2,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0]        ent_ready,
    input  logic [NUM_REGS*TAG_W-1:0]  ent_tag,
    input  logic [REG_W-1:0]           sel_reg,
    input  logic [NUM_PORTS-1:0]       cmp_valid,
    input  logic [NUM_PORTS*TAG_W-1:0] cmp_tag,
    output logic                       out_ready,
    output logic [TAG_W-1:0]           out_tag
);
    logic byp_hit;

    assign out_tag = ent_tag[int'(sel_reg)*TAG_W +: TAG_W];

    rat_wakeup #(
        .TAG_W     (TAG_W),
        .NUM_PORTS (NUM_PORTS)
    ) byp_i (
        .entry_tag (out_tag),
        .cmp_valid (cmp_valid),
        .cmp_tag   (cmp_tag),
        .hit       (byp_hit)
    );

    assign out_ready = ent_ready[sel_reg] | byp_hit;
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table
    import rat_pkg::*;
#(
    parameter int NUM_REGS  = RAT_NUM_REGS,
    parameter int TAG_W     = RAT_TAG_W,
    parameter int NUM_SRC   = RAT_NUM_SRC,
    parameter int NUM_PORTS = RAT_NUM_PORTS,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       iss_valid,
    input  logic [NUM_SRC*REG_W-1:0]   iss_src_reg,
    input  logic                       iss_dst_valid,
    input  logic [REG_W-1:0]           iss_dst_reg,
    input  logic [TAG_W-1:0]           iss_new_tag,
    output logic [NUM_SRC-1:0]         src_ready,
    output logic [NUM_SRC*TAG_W-1:0]   src_tag,
    input  logic [NUM_PORTS-1:0]       cmp_valid,
    input  logic [NUM_PORTS*TAG_W-1:0] cmp_tag
);
    logic [NUM_REGS-1:0]       ent_ready;
    logic [NUM_REGS*TAG_W-1:0] ent_tag;
    logic [NUM_REGS-1:0]       ent_rename;
    logic [NUM_REGS-1:0]       ent_hit;
    logic                      do_rename;

    assign do_rename = iss_valid & iss_dst_valid;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        assign ent_rename[i] = do_rename && (iss_dst_reg == REG_W'(i));

        rat_wakeup #(
            .TAG_W     (TAG_W),
            .NUM_PORTS (NUM_PORTS)
        ) wake_i (
            .entry_tag (ent_tag[i*TAG_W +: TAG_W]),
            .cmp_valid (cmp_valid),
            .cmp_tag   (cmp_tag),
            .hit       (ent_hit[i])
        );

        rat_entry #(
            .TAG_W     (TAG_W),
            .RESET_TAG (i)
        ) ent_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .rename_en  (ent_rename[i]),
            .rename_tag (iss_new_tag),
            .wake_hit   (ent_hit[i]),
            .ready      (ent_ready[i]),
            .tag        (ent_tag[i*TAG_W +: TAG_W])
        );
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        rat_src_read #(
            .NUM_REGS  (NUM_REGS),
            .TAG_W     (TAG_W),
            .NUM_PORTS (NUM_PORTS)
        ) rd_i (
            .ent_ready (ent_ready),
            .ent_tag   (ent_tag),
            .sel_reg   (iss_src_reg[k*REG_W +: REG_W]),
            .cmp_valid (cmp_valid),
            .cmp_tag   (cmp_tag),
            .out_ready (src_ready[k]),
            .out_tag   (src_tag[k*TAG_W +: TAG_W])
        );
    end
endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
    parameter int NUM_REGS  = 16,
    parameter int TAG_W     = 7,
    parameter int NUM_SRC   = 2,
    parameter int NUM_PORTS = 2,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       iss_valid,
    input logic [NUM_SRC*REG_W-1:0]   iss_src_reg,
    input logic                       iss_dst_valid,
    input logic [REG_W-1:0]           iss_dst_reg,
    input logic [TAG_W-1:0]           iss_new_tag,
    input logic [NUM_SRC-1:0]         src_ready,
    input logic [NUM_SRC*TAG_W-1:0]   src_tag,
    input logic [NUM_PORTS-1:0]       cmp_valid,
    input logic [NUM_PORTS*TAG_W-1:0] cmp_tag,
    input logic [NUM_REGS-1:0]        ent_ready,
    input logic [NUM_REGS*TAG_W-1:0]  ent_tag
);
    logic ren;
    assign ren = iss_valid & iss_dst_valid;

    // R3 and R6: a rename always leaves the entry pending under the new tag
    p_rename_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ren |=> (!ent_ready[$past(iss_dst_reg)]
                 && ent_tag[int'($past(iss_dst_reg))*TAG_W +: TAG_W] == $past(iss_new_tag)));

    // R8: with no qualified rename and no valid broadcast, nothing moves
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren && cmp_valid == '0) |=> ($stable(ent_ready) && $stable(ent_tag)));

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        logic hit_i;
        always_comb begin
            hit_i = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (cmp_valid[p] && cmp_tag[p*TAG_W +: TAG_W] == ent_tag[i*TAG_W +: TAG_W]) begin
                    hit_i = 1'b1;
                end
            end
        end
        // R4: matching broadcast wakes an entry that is not being renamed
        p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i && !(ren && iss_dst_reg == REG_W'(i))) |=> ent_ready[i]);
        // R6: rename and wakeup collide, rename wins
        p_rename_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i && ren && iss_dst_reg == REG_W'(i)) |=> !ent_ready[i]);
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        logic [REG_W-1:0] sreg;
        logic             byp;
        assign sreg = iss_src_reg[k*REG_W +: REG_W];
        always_comb begin
            byp = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (cmp_valid[p] && cmp_tag[p*TAG_W +: TAG_W] == src_tag[k*TAG_W +: TAG_W]) begin
                    byp = 1'b1;
                end
            end
        end
        // R2: tag output follows the selected entry
        p_lookup_r2: assert property (@(posedge clk) disable iff (!rst_n)
            src_tag[k*TAG_W +: TAG_W] == ent_tag[int'(sreg)*TAG_W +: TAG_W]);
        // R5: a tag on a valid broadcast is reported ready in the same cycle
        p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
            byp |-> src_ready[k]);
        // R2: with no bypass, ready follows the stored flag
        p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !byp |-> (src_ready[k] == ent_ready[sreg]));
    end
endmodule

bind rename_alias_table rat_checker #(
    .NUM_REGS  (NUM_REGS),
    .TAG_W     (TAG_W),
    .NUM_SRC   (NUM_SRC),
    .NUM_PORTS (NUM_PORTS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .iss_valid     (iss_valid),
    .iss_src_reg   (iss_src_reg),
    .iss_dst_valid (iss_dst_valid),
    .iss_dst_reg   (iss_dst_reg),
    .iss_new_tag   (iss_new_tag),
    .src_ready     (src_ready),
    .src_tag       (src_tag),
    .cmp_valid     (cmp_valid),
    .cmp_tag       (cmp_tag),
    .ent_ready     (ent_ready),
    .ent_tag       (ent_tag)
);

// File: tb/rename_alias_table_tb_top.sv
module rename_alias_table_tb_top;
    localparam int NR = 16;
    localparam int TW = 7;
    localparam int NS = 2;
    localparam int NP = 2;
    localparam int RW = $clog2(NR);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [NS*RW-1:0]  iss_src_reg = '0;
    logic              iss_dst_valid = 1'b0;
    logic [RW-1:0]     iss_dst_reg = '0;
    logic [TW-1:0]     iss_new_tag = '0;
    logic [NS-1:0]     src_ready;
    logic [NS*TW-1:0]  src_tag;
    logic [NP-1:0]     cmp_valid = '0;
    logic [NP*TW-1:0]  cmp_tag = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    rename_alias_table dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_src_reg(iss_src_reg),
        .iss_dst_valid(iss_dst_valid), .iss_dst_reg(iss_dst_reg), .iss_new_tag(iss_new_tag),
        .src_ready(src_ready), .src_tag(src_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0; iss_dst_valid = 1'b0; cmp_valid = '0;
    endtask

    task automatic step();
        @(posedge clk); #1; idle();
    endtask

    task automatic peek(input int r, output int rdy, output int tg);
        idle();
        iss_src_reg[0 +: RW] = RW'(r);
        #1;
        rdy = int'(src_ready[0]);
        tg  = int'(src_tag[0 +: TW]);
    endtask

    task automatic expect_entry(input string req, input int r, input int rdy_e, input int tag_e);
        int rdy, tg;
        peek(r, rdy, tg);
        check({req, " ready"}, rdy, rdy_e);
        check({req, " tag"}, tg, tag_e);
    endtask

    task automatic issue(input int s0, input int s1, input int dv, input int d, input int t);
        @(negedge clk);
        iss_valid = 1'b1;
        iss_src_reg[0 +: RW] = RW'(s0);
        iss_src_reg[RW +: RW] = RW'(s1);
        iss_dst_valid = dv[0];
        iss_dst_reg = RW'(d);
        iss_new_tag = TW'(t);
    endtask

    task automatic bcast(input int p, input int t);
        cmp_valid[p] = 1'b1;
        cmp_tag[p*TW +: TW] = TW'(t);
    endtask

    task automatic t_reset();
        for (int r = 0; r < NR; r++) expect_entry("R1", r, 1, r);
    endtask

    task automatic t_rename_and_wake();
        issue(1, 2, 1, 3, 40);
        #1;
        check("R2 src0 ready", int'(src_ready[0]), 1);
        check("R2 src1 tag", int'(src_tag[TW +: TW]), 2);
        step();
        expect_entry("R3", 3, 0, 40);
        @(negedge clk); idle(); bcast(0, 40);
        step();
        expect_entry("R4 woken", 3, 1, 40);
        expect_entry("R4 untouched", 4, 1, 4);
    endtask

    task automatic t_bypass();
        issue(5, 5, 1, 5, 50);
        step();
        issue(5, 6, 0, 0, 0);
        bcast(1, 50);
        #1;
        check("R5 bypass ready", int'(src_ready[0]), 1);
        check("R5 bypass tag", int'(src_tag[0 +: TW]), 50);
        check("R2 src1 tag", int'(src_tag[TW +: TW]), 6);
        step();
        expect_entry("R9 port1 wake", 5, 1, 50);
    endtask

    task automatic t_rename_wins();
        issue(0, 0, 1, 7, 60);
        step();
        issue(0, 0, 1, 7, 61);
        bcast(0, 60);
        step();
        expect_entry("R6", 7, 0, 61);
        @(negedge clk); idle(); bcast(1, 61);
        step();
        expect_entry("R6 later wake", 7, 1, 61);
    endtask

    task automatic t_same_src_dst();
        issue(0, 0, 1, 8, 70);
        step();
        issue(8, 8, 1, 8, 71);
        #1;
        check("R7 src ready old", int'(src_ready[0]), 0);
        check("R7 src tag old", int'(src_tag[0 +: TW]), 70);
        check("R10 same reg tags", int'(src_tag[TW +: TW]), int'(src_tag[0 +: TW]));
        check("R10 same reg ready", int'(src_ready[1]), int'(src_ready[0]));
        step();
        expect_entry("R7 after", 8, 0, 71);
    endtask

    task automatic t_ignored();
        @(negedge clk);
        idle();
        iss_dst_valid = 1'b1; iss_dst_reg = RW'(9); iss_new_tag = TW'(80);
        cmp_tag[0 +: TW] = TW'(71);
        step();
        expect_entry("R8 no issue", 9, 1, 9);
        expect_entry("R8 no bcast", 8, 0, 71);
        issue(0, 0, 0, 9, 81);
        step();
        expect_entry("R8 no dst", 9, 1, 9);
    endtask

    task automatic t_dual_and_stale();
        issue(0, 0, 1, 10, 90);
        step();
        issue(0, 0, 1, 11, 91);
        step();
        issue(0, 0, 1, 12, 100);
        step();
        issue(0, 0, 1, 12, 101);
        step();
        @(negedge clk); idle(); bcast(0, 90); bcast(1, 91);
        step();
        expect_entry("R9 port0", 10, 1, 90);
        expect_entry("R9 port1", 11, 1, 91);
        @(negedge clk); idle(); bcast(0, 100);
        step();
        expect_entry("R4 stale tag", 12, 0, 101);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rename_and_wake();
        t_bypass();
        t_rename_wins();
        t_same_src_dst();
        t_ignored();
        t_dual_and_stale();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule